// File: doc/BRIEF.md
# Fine Digital Gain Trim

This block applies a small, positive-only gain correction to a stream of signed converter samples, one sample per clock. A 7-bit unsigned trim code `k` selects the linear gain `1 + k/8192`. A code of zero leaves the stream unchanged. The largest code raises the gain by about 0.134 dB. The stage sits after the coarse gain stage and does not depend on it, so the two gains simply add in decibels.

Each accepted sample is multiplied by the trim code. The product is shifted down by 13 bits with round-half-up, added back onto the sample, and clamped to the sample range. The trim code is captured together with the sample it applies to. A new code therefore affects only the samples accepted after the change, and samples already in flight are untouched. The pipeline has a fixed latency of two clocks, and the valid strobe is delayed to match.

Top module: `fine_gain_trim`

## Requirements
- R1: While `rst` is high at a clock edge, the next state has `out_valid` = 0 and `out_data` = 0.
- R2: `out_valid` equals `in_valid` as sampled two clock edges earlier, so the latency is exactly two cycles.
- R3: With trim code 0, every output sample equals its input sample.
- R4: For a sample `s` (two's complement, `SAMPLE_W` bits, default 12) and code `k` (unsigned, 7 bits), the output is `s + floor((s*k + 4096) / 8192)`, provided that value fits the sample range.
- R5: The trim never lowers the gain. A non-negative input gives an output at or above the input, and a negative input gives an output at or below the input.
- R6: A result above the largest sample value (2047 at 12 bits) is clamped to that value.
- R7: A result below the smallest sample value (-2048 at 12 bits) is clamped to that value.
- R8: The trim code is taken in the same cycle as the sample. When the code changes between back-to-back samples, each sample is scaled by its own code.
- R9: While `out_valid` is 0, `out_data` keeps the last value it held.
- R10: An exact half LSB in the scaled correction rounds toward positive infinity. So (64, k=64) gives 65, and (-64, k=64) gives -64.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample strobe |
| in_data | input | SAMPLE_W | Signed input sample |
| in_code | input | CODE_W | Unsigned trim code, gain = 1 + code/8192 |
| out_valid | output | 1 | Output sample strobe, two cycles after `in_valid` |
| out_data | output | SAMPLE_W | Trimmed, rounded and saturated signed sample |

## Verification
Four properties are checked on every cycle: the two-cycle alignment of the strobe, the direction of the trim (the output never moves toward zero), unity gain at code zero, and the held output between strobes. The exact rounding values are shown only by the bench's scenarios, which compare every clock against a behavioural model. These scenarios include the half-LSB corners, clamping at both rails, a sweep over all 128 codes, and code changes between back-to-back samples.

// File: rtl/gain_trim_pkg.sv
package gain_trim_pkg;

    localparam int DEF_SAMPLE_W = 12;
    localparam int DEF_CODE_W   = 7;
    localparam int TRIM_FRAC    = 13;

    typedef enum logic [1:0] {
        CLAMP_NONE = 2'd0,
        CLAMP_HIGH = 2'd1,
        CLAMP_LOW  = 2'd2
    } clamp_e;

    function automatic int prod_width(input int sw, input int cw);
        return sw + cw + 1;
    endfunction

endpackage

// File: rtl/fgt_capture.sv
module fgt_capture
    import gain_trim_pkg::*;
#(
    parameter int SAMPLE_W = DEF_SAMPLE_W,
    parameter int CODE_W   = DEF_CODE_W,
    localparam int PROD_W  = prod_width(SAMPLE_W, CODE_W)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       in_valid,
    input  logic signed [SAMPLE_W-1:0] in_data,
    input  logic        [CODE_W-1:0]   in_code,
    output logic                       s1_valid,
    output logic signed [SAMPLE_W-1:0] s1_sample,
    output logic signed [PROD_W-1:0]   s1_prod
);

    typedef struct packed {
        logic                       valid;
        logic signed [SAMPLE_W-1:0] sample;
        logic signed [PROD_W-1:0]   prod;
    } cap_t;

    cap_t cap_q;
    logic signed [PROD_W-1:0] ext_sample;
    logic signed [PROD_W-1:0] ext_code;
    logic signed [PROD_W-1:0] prod_c;

    // Sign-extend the sample, zero-extend the code: the product fits in PROD_W.
    assign ext_sample = {{(PROD_W-SAMPLE_W){in_data[SAMPLE_W-1]}}, in_data};
    assign ext_code   = {{(PROD_W-CODE_W){1'b0}}, in_code};
    assign prod_c     = ext_sample * ext_code;

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_q <= '0;
        end else begin
            cap_q.valid <= in_valid;
            if (in_valid) begin
                cap_q.sample <= in_data;
                cap_q.prod   <= prod_c;
            end
        end
    end

    assign s1_valid  = cap_q.valid;
    assign s1_sample = cap_q.sample;
    assign s1_prod   = cap_q.prod;

endmodule

// File: rtl/fgt_round_sat.sv
module fgt_round_sat
    import gain_trim_pkg::*;
#(
    parameter int SAMPLE_W = DEF_SAMPLE_W,
    parameter int CODE_W   = DEF_CODE_W,
    parameter int FRAC     = TRIM_FRAC,
    localparam int PROD_W  = prod_width(SAMPLE_W, CODE_W),
    localparam int SUM_W   = PROD_W + 1
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       s1_valid,
    input  logic signed [SAMPLE_W-1:0] s1_sample,
    input  logic signed [PROD_W-1:0]   s1_prod,
    output logic                       out_valid,
    output logic signed [SAMPLE_W-1:0] out_data
);

    localparam logic signed [SUM_W-1:0] HALF_LSB = SUM_W'(1) <<< (FRAC - 1);
    localparam logic signed [SUM_W-1:0] TOP_V    = SUM_W'((1 <<< (SAMPLE_W - 1)) - 1);
    localparam logic signed [SUM_W-1:0] BOT_V    = -TOP_V - SUM_W'(1);
    localparam logic [SAMPLE_W-1:0]     TOP_S    = {1'b0, {(SAMPLE_W-1){1'b1}}};
    localparam logic [SAMPLE_W-1:0]     BOT_S    = {1'b1, {(SAMPLE_W-1){1'b0}}};

    typedef struct packed {
        logic                       valid;
        logic signed [SAMPLE_W-1:0] data;
    } res_t;

    logic signed [SUM_W-1:0] prod_ext;
    logic signed [SUM_W-1:0] biased;
    logic signed [SUM_W-1:0] delta;
    logic signed [SUM_W-1:0] total;
    clamp_e                  clamp;
    logic signed [SAMPLE_W-1:0] next_data;
    res_t                    res_q;

    always_comb begin
        prod_ext = {s1_prod[PROD_W-1], s1_prod};
        biased   = prod_ext + HALF_LSB;
        delta    = biased >>> FRAC;
        total    = {{(SUM_W-SAMPLE_W){s1_sample[SAMPLE_W-1]}}, s1_sample} + delta;
        if (total > TOP_V)      clamp = CLAMP_HIGH;
        else if (total < BOT_V) clamp = CLAMP_LOW;
        else                    clamp = CLAMP_NONE;
        unique case (clamp)
            CLAMP_HIGH: next_data = TOP_S;
            CLAMP_LOW:  next_data = BOT_S;
            default:    next_data = total[SAMPLE_W-1:0];
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q <= '0;
        end else begin
            res_q.valid <= s1_valid;
            if (s1_valid) begin
                res_q.data <= next_data;
            end
        end
    end

    assign out_valid = res_q.valid;
    assign out_data  = res_q.data;

endmodule

// File: rtl/fine_gain_trim.sv
module fine_gain_trim
    import gain_trim_pkg::*;
#(
    parameter int SAMPLE_W = DEF_SAMPLE_W,
    parameter int CODE_W   = DEF_CODE_W,
    localparam int PROD_W  = prod_width(SAMPLE_W, CODE_W)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       in_valid,
    input  logic signed [SAMPLE_W-1:0] in_data,
    input  logic        [CODE_W-1:0]   in_code,
    output logic                       out_valid,
    output logic signed [SAMPLE_W-1:0] out_data
);

    logic                       s1_valid;
    logic signed [SAMPLE_W-1:0] s1_sample;
    logic signed [PROD_W-1:0]   s1_prod;

    fgt_capture #(
        .SAMPLE_W (SAMPLE_W),
        .CODE_W   (CODE_W)
    ) u_capture (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .in_code   (in_code),
        .s1_valid  (s1_valid),
        .s1_sample (s1_sample),
        .s1_prod   (s1_prod)
    );

    fgt_round_sat #(
        .SAMPLE_W (SAMPLE_W),
        .CODE_W   (CODE_W),
        .FRAC     (TRIM_FRAC)
    ) u_round_sat (
        .clk       (clk),
        .rst       (rst),
        .s1_valid  (s1_valid),
        .s1_sample (s1_sample),
        .s1_prod   (s1_prod),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

endmodule

// File: rtl/fgt_checker.sv
module fgt_checker #(
    parameter int SAMPLE_W = 12,
    parameter int CODE_W   = 7
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       in_valid,
    input logic signed [SAMPLE_W-1:0] in_data,
    input logic        [CODE_W-1:0]   in_code,
    input logic                       out_valid,
    input logic signed [SAMPLE_W-1:0] out_data
);

    logic [1:0] warm;
    logic       armed;

    always_ff @(posedge clk) begin
        if (rst)             warm <= 2'd0;
        else if (warm != 2'd2) warm <= warm + 2'd1;
    end
    assign armed = (warm == 2'd2);

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (!out_valid && out_data == '0)); // R1

    AST_TWO_CYCLE_STROBE: assert property (@(posedge clk) disable iff (rst)
        armed |-> (out_valid == $past(in_valid, 2))); // R2

    AST_UNITY_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
        (armed && out_valid && $past(in_code, 2) == '0) |-> (out_data == $past(in_data, 2))); // R3

    AST_NEVER_SHRINKS: assert property (@(posedge clk) disable iff (rst)
        (armed && out_valid) |->
            (($past(in_data, 2) >= 0) ? (out_data >= $past(in_data, 2))
                                      : (out_data <= $past(in_data, 2)))); // R5

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        (armed && !out_valid) |-> $stable(out_data)); // R9

endmodule

bind fine_gain_trim fgt_checker #(
    .SAMPLE_W (SAMPLE_W),
    .CODE_W   (CODE_W)
) u_fgt_checker (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .in_code   (in_code),
    .out_valid (out_valid),
    .out_data  (out_data)
);

// File: tb/fine_gain_trim_test.sv
`timescale 1ns/1ps
module fine_gain_trim_test;

    localparam int SW   = 12;
    localparam int CW   = 7;
    localparam int TOPV = (1 << (SW - 1)) - 1;
    localparam int BOTV = -(1 << (SW - 1));

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 in_valid = 1'b0;
    logic signed [SW-1:0] in_data = '0;
    logic        [CW-1:0] in_code = '0;
    logic                 out_valid;
    logic signed [SW-1:0] out_data;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;
    bit seen_edge = 1'b0;
    string cur_req = "R4";

    bit q_valid[$];
    int q_data[$];
    int held = 0;

    always #4 clk = ~clk;

    fine_gain_trim uut (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .in_code   (in_code),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    function automatic int ref_trim(input int s, input int k);
        int corr;
        int r;
        corr = (s * k + 4096) >>> 13;
        r = s + corr;
        if (r > TOPV) r = TOPV;
        if (r < BOTV) r = BOTV;
        return r;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // Reference model: record each sampled input, compare every clock.
    always @(posedge clk) begin
        seen_edge <= 1'b1;
        if (rst) begin
            q_valid.delete();
            q_data.delete();
            held = 0;
        end else begin
            if (q_valid.size() == 2) begin
                void'(q_valid.pop_front());
                void'(q_data.pop_front());
            end
            q_valid.push_back(in_valid);
            q_data.push_back(ref_trim(int'(in_data), int'(in_code)));
        end
    end

    always @(negedge clk) begin
        if (!done && seen_edge) begin
            if (rst) begin
                check("R1 valid", int'(out_valid), 0);
                check("R1 data", int'(out_data), 0);
            end else if (q_valid.size() == 2) begin
                if (q_valid[0]) held = q_data[0];
                check("R2", int'(out_valid), int'(q_valid[0]));
                check(q_valid[0] ? cur_req : "R9", int'(out_data), held);
            end
        end
    end

    task automatic send_one(input int s, input int k, input int exp, input string req);
        @(negedge clk);
        in_valid = 1'b1; in_data = SW'(s); in_code = CW'(k);
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        check({req, " strobe"}, int'(out_valid), 1);
        check(req, int'(out_data), exp);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);

        // Directed corners with hand-computed results
        cur_req = "R3";  send_one(1000, 0, 1000, "R3");
        cur_req = "R3";  send_one(-1500, 0, -1500, "R3");
        cur_req = "R4";  send_one(1000, 127, 1016, "R4");
        cur_req = "R4";  send_one(2000, 127, 2031, "R4");
        cur_req = "R10"; send_one(64, 64, 65, "R10");
        cur_req = "R10"; send_one(-64, 64, -64, "R10");
        cur_req = "R6";  send_one(2047, 127, 2047, "R6");
        cur_req = "R6";  send_one(2030, 127, 2047, "R6");
        cur_req = "R7";  send_one(-2048, 127, -2048, "R7");

        // R9: output holds across an idle gap
        repeat (3) @(negedge clk);
        check("R9 strobe", int'(out_valid), 0);
        check("R9", int'(out_data), -2048);

        // R8: code changes between back-to-back samples
        cur_req = "R8";
        @(negedge clk);
        in_valid = 1'b1; in_data = 12'sd1000; in_code = 7'd127;
        @(negedge clk);
        in_code = 7'd0;
        @(negedge clk);
        in_valid = 1'b0; in_code = 7'd64;
        check("R8", int'(out_data), 1016);
        @(negedge clk);
        check("R8", int'(out_data), 1000);

        // R4: sweep every code with a spread of samples
        cur_req = "R4";
        for (int k = 0; k < 128; k++) begin
            for (int j = 0; j < 8; j++) begin
                @(negedge clk);
                in_valid = 1'b1;
                in_code  = CW'(k);
                in_data  = SW'(-2048 + j * 585);
            end
        end

        // R5: random valid pattern, random codes and samples
        cur_req = "R5";
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            in_valid = 1'(($urandom % 3) != 0);
            in_code  = CW'($urandom);
            in_data  = SW'($urandom);
        end

        // R6/R7: samples near both rails with random codes
        cur_req = "R6";
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_code  = CW'($urandom);
            in_data  = (i % 2 == 0) ? SW'(TOPV - int'($urandom % 40)) : SW'(BOTV + int'($urandom % 40));
        end
        @(negedge clk);
        in_valid = 1'b0;
        repeat (4) @(negedge clk);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule